// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a host that can only issue 32-bit stores and a set of control registers that are wider than one store. Dword writes arrive on a valid/ready port. The block gathers them into 128-bit control registers and 64-bit memory words. Each register is committed in one step: a single-cycle strobe, the register's base byte address, and the full 128-bit value, which also updates a small backing register file. Dword reads are answered from that backing file one cycle after they are accepted.

Per-queue registers are page mapped, at page × stride + offset. Two of them are plain 32-bit registers that commit at once: the event-queue read pointer at offset 0x400 and the timer command at offset 0x420. Two of them are 128-bit write-only descriptor-pointer registers: receive at 0x830 and transmit at 0xA10. These follow looser collector rules, so the host can update them without a lock. A lone write to their top dword commits them with the missing low bits zero-filled. A lower-dword write that would disturb a foreign collection is dropped instead.

Only one collector is shared by all wide registers. Interleaving dword writes to two different wide registers therefore loses data, and the block shows that loss rather than hiding it. Both ports are always ready. `wr_ready` and `rd_ready` are held high, so a write or read is taken in every cycle its valid is high and the host never stalls.

Top module: `wide_write_collector`

## Requirements
- R1: A 128-bit control register (default: four registers at byte 0x000, 16 bytes apart) commits only once all four dwords are held. The dwords may arrive in any order. Byte offset 0 carries bits 31:0, offset 4 bits 63:32, offset 8 bits 95:64 and offset 12 bits 127:96. `commit_valid` is high for exactly the one cycle after the completing write, and `commit_addr` then equals the register's base.
- R2: A 64-bit memory word (default: four words at byte 0x100, 8 bytes apart) commits once both of its dwords are held. Offset 0 carries bits 31:0 and offset 4 carries bits 63:32. Bits 127:64 of `commit_data` are zero.
- R3: Suppose the collector holds part of one wide register and a control-register or memory-word dword arrives for a different one. The held data is then discarded, and collection restarts from the new dword alone, with the other dwords zero.
- R4: Writing a dword position that is already held, before the register completes, replaces the held value.
- R5: A write to the top dword of a descriptor register (offset 0x83C or 0xA1C within a page) always commits that register in the next cycle. The commit address is offset 0x830 or 0xA10. Bits 127:96 carry the written data. The low 96 bits come from the collector if it holds this same register, and any position not held is zero. The collector is cleared only if it held this register; otherwise it is left as it was.
- R6: A write to a lower dword of a descriptor register is dropped while the collector holds data for any other register, and the collector keeps its contents.
- R7: Writes to offsets 0x400 and 0x420 of a valid page commit in the next cycle. The commit address is the written address and the data is zero-extended to 128 bits. These writes do not use or disturb the collector.
- R8: When parameter `TIMER_CLEARS` is 1, a write to offset 0x420 of page 0 also empties the collector. The same write in any other page leaves the collector intact.
- R9: The page index is the address divided by `PAGE_STRIDE` (default 0x2000). Addresses in pages at or beyond `NUM_PAGES` (default 2) are ignored, and so are other unmapped addresses: they produce no commit and read back as zero.
- R10: A read accepted in one cycle sets `rd_resp_valid` in the next, carrying the dword last committed at that address. Descriptor registers and unmapped addresses read as zero. A partly collected value is not visible to reads.
- R11: After reset, no commit is pending, the collector is empty and every backing register reads zero. `wr_ready` and `rd_ready` stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write dword offered |
| wr_ready | output | 1 | Write accepted (held high) |
| wr_addr | input | ADDR_W | Byte address of the dword |
| wr_data | input | 32 | Write dword |
| rd_valid | input | 1 | Read dword requested |
| rd_ready | output | 1 | Read accepted (held high) |
| rd_addr | input | ADDR_W | Byte address to read |
| rd_resp_valid | output | 1 | Read data present, one cycle after acceptance |
| rd_resp_data | output | 32 | Read dword |
| commit_valid | output | 1 | One-cycle strobe per committed register |
| commit_addr | output | ADDR_W | Base byte address of the committed register |
| commit_data | output | 128 | Full value committed |

## Verification
The collector is driven with dwords in shuffled order, with the same dword repeated, and with writes to two registers interleaved. These patterns separate ordered completion, overwrite and restart-with-loss. Descriptor registers get three cases: a full gather, a lone top-dword write, and a top-dword write while a foreign collection is open. These distinguish zero-fill from merge, and a collector that is left alone from one that is cleared. Dropped lower-dword writes, plain page registers and the timer write in page 0 versus page 1 are each followed by completing the pending register, so the commit value shows whether the collector survived. Reads after commits, after partial writes and to unmapped pages check what the backing file exposes.

// File: rtl/wwc_pkg.sv
package wwc_pkg;
  localparam int IDX_W = 8;
  localparam int DW    = 32;
  localparam int WIDE  = 128;

  // per-page register offsets; the descriptor high dword sits at +12
  localparam int OFF_EVQ = 'h400;
  localparam int OFF_TMR = 'h420;
  localparam int OFF_DRX = 'h830;
  localparam int OFF_DTX = 'hA10;

  typedef enum logic [2:0] {
    K_NONE,
    K_CSR,
    K_SRAM,
    K_EVQ,
    K_TMR,
    K_DRX,
    K_DTX
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [IDX_W-1:0] idx;
    logic [1:0]       sel;
  } dec_t;

  function automatic logic is_desc(kind_e k);
    return (k == K_DRX) || (k == K_DTX);
  endfunction
endpackage

// File: rtl/wwc_decode.sv
module wwc_decode
  import wwc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int NUM_CSR     = 4,
  parameter int CSR_BASE    = 'h000,
  parameter int NUM_SRAM    = 4,
  parameter int SRAM_BASE   = 'h100,
  parameter int NUM_PAGES   = 2,
  parameter int PAGE_STRIDE = 'h2000
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec,
  output logic [ADDR_W-1:0] base
);
  localparam int PAGE_SH  = $clog2(PAGE_STRIDE);
  localparam int CSR_END  = CSR_BASE + 16 * NUM_CSR;
  localparam int SRAM_END = SRAM_BASE + 8 * NUM_SRAM;

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] page;
  logic [ADDR_W-1:0] base16;
  logic [ADDR_W-1:0] base8;

  assign off    = addr & ADDR_W'(PAGE_STRIDE - 1);
  assign page   = addr >> PAGE_SH;
  assign base16 = addr & ~ADDR_W'(15);
  assign base8  = addr & ~ADDR_W'(7);

  always_comb begin
    dec.kind = K_NONE;
    dec.idx  = '0;
    dec.sel  = addr[3:2];
    base     = addr;
    if (int'(addr) >= CSR_BASE && int'(addr) < CSR_END) begin
      // R1: 16-byte control registers, dword select from address bits 3:2
      dec.kind = K_CSR;
      dec.idx  = IDX_W'((addr - ADDR_W'(CSR_BASE)) >> 4);
      base     = base16;
    end else if (int'(addr) >= SRAM_BASE && int'(addr) < SRAM_END) begin
      // R2: 8-byte memory words, dword select from address bit 2
      dec.kind = K_SRAM;
      dec.idx  = IDX_W'((addr - ADDR_W'(SRAM_BASE)) >> 3);
      dec.sel  = {1'b0, addr[2]};
      base     = base8;
    end else if (int'(page) < NUM_PAGES) begin
      // R9: page-mapped queue registers
      dec.idx = IDX_W'(page);
      if (off == ADDR_W'(OFF_EVQ)) begin
        dec.kind = K_EVQ;
      end else if (off == ADDR_W'(OFF_TMR)) begin
        dec.kind = K_TMR;
      end else if ((off & ~ADDR_W'(15)) == ADDR_W'(OFF_DRX)) begin
        dec.kind = K_DRX;
        base     = base16;
      end else if ((off & ~ADDR_W'(15)) == ADDR_W'(OFF_DTX)) begin
        dec.kind = K_DTX;
        base     = base16;
      end
    end
  end
endmodule

// File: rtl/wwc_collector.sv
module wwc_collector
  import wwc_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter bit TIMER_CLEARS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  dec_t              wr_dec,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [DW-1:0]     wr_data,
  output logic              commit_valid,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [WIDE-1:0]   commit_data,
  output kind_e             commit_kind,
  output logic [IDX_W-1:0]  commit_idx
);
  logic [3:0]       mask_q, mask_d;
  kind_e            tkind_q, tkind_d;
  logic [IDX_W-1:0] tidx_q, tidx_d;
  logic [WIDE-1:0]  data_q, data_d;

  logic              cv_d;
  logic [ADDR_W-1:0] ca_d;
  logic [WIDE-1:0]   cd_d;

  logic            busy, hit;
  logic [3:0]      merged_mask, full_mask;
  logic [WIDE-1:0] merged_data;

  always_comb begin
    busy = (mask_q != 4'b0);
    hit  = busy && (tkind_q == wr_dec.kind) && (tidx_q == wr_dec.idx);

    // R3/R4: merge into a matching collection, else start from zero
    merged_mask = hit ? mask_q : 4'b0;
    merged_data = hit ? data_q : '0;
    merged_mask[wr_dec.sel] = 1'b1;
    merged_data[wr_dec.sel * DW +: DW] = wr_data;
    full_mask = (wr_dec.kind == K_SRAM) ? 4'b0011 : 4'b1111;

    mask_d  = mask_q;
    tkind_d = tkind_q;
    tidx_d  = tidx_q;
    data_d  = data_q;
    cv_d    = 1'b0;
    ca_d    = wr_base;
    cd_d    = '0;

    if (wr_fire) begin
      case (wr_dec.kind)
        K_CSR, K_SRAM: begin
          if (merged_mask == full_mask) begin
            // R1/R2: complete, commit and clear
            cv_d   = 1'b1;
            cd_d   = merged_data;
            mask_d = 4'b0;
            data_d = '0;
          end else begin
            mask_d  = merged_mask;
            data_d  = merged_data;
            tkind_d = wr_dec.kind;
            tidx_d  = wr_dec.idx;
          end
        end
        K_DRX, K_DTX: begin
          if (wr_dec.sel == 2'd3) begin
            // R5: high dword always commits, missing low bits are zero
            cv_d = 1'b1;
            cd_d = {wr_data, (hit ? data_q[3*DW-1:0] : {(3*DW){1'b0}})};
            if (hit) begin
              mask_d = 4'b0;
              data_d = '0;
            end
          end else if (!busy || hit) begin
            mask_d  = merged_mask;
            data_d  = merged_data;
            tkind_d = wr_dec.kind;
            tidx_d  = wr_dec.idx;
          end
          // R6: otherwise the write is dropped and state is kept
        end
        K_EVQ, K_TMR: begin
          // R7: narrow registers bypass the collector
          cv_d = 1'b1;
          cd_d = {{(WIDE-DW){1'b0}}, wr_data};
          // R8: modelled quirk, timer write in page 0 empties the collector
          if (TIMER_CLEARS && wr_dec.kind == K_TMR && wr_dec.idx == '0) begin
            mask_d = 4'b0;
            data_d = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q       <= 4'b0;
      tkind_q      <= K_NONE;
      tidx_q       <= '0;
      data_q       <= '0;
      commit_valid <= 1'b0;
      commit_addr  <= '0;
      commit_data  <= '0;
      commit_kind  <= K_NONE;
      commit_idx   <= '0;
    end else begin
      mask_q       <= mask_d;
      tkind_q      <= tkind_d;
      tidx_q       <= tidx_d;
      data_q       <= data_d;
      commit_valid <= cv_d;
      commit_addr  <= ca_d;
      commit_data  <= cd_d;
      commit_kind  <= cv_d ? wr_dec.kind : K_NONE;
      commit_idx   <= wr_dec.idx;
    end
  end
endmodule

// File: rtl/wwc_regfile.sv
module wwc_regfile
  import wwc_pkg::*;
#(
  parameter int NUM_CSR   = 4,
  parameter int NUM_SRAM  = 4,
  parameter int NUM_PAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_valid,
  input  kind_e            commit_kind,
  input  logic [IDX_W-1:0] commit_idx,
  input  logic [WIDE-1:0]  commit_data,
  input  logic             rd_fire,
  input  dec_t             rd_dec,
  output logic             rd_resp_valid,
  output logic [DW-1:0]    rd_resp_data
);
  logic [WIDE-1:0] csr_q  [NUM_CSR];
  logic [2*DW-1:0] sram_q [NUM_SRAM];
  logic [DW-1:0]   evq_q  [NUM_PAGES];
  logic [DW-1:0]   tmr_q  [NUM_PAGES];
  logic [DW-1:0]   rd_word;

  for (genvar i = 0; i < NUM_CSR; i++) begin : g_csr
    always_ff @(posedge clk) begin
      if (!rst_n) csr_q[i] <= '0;
      else if (commit_valid && commit_kind == K_CSR && commit_idx == IDX_W'(i))
        csr_q[i] <= commit_data;
    end
  end

  for (genvar i = 0; i < NUM_SRAM; i++) begin : g_sram
    always_ff @(posedge clk) begin
      if (!rst_n) sram_q[i] <= '0;
      else if (commit_valid && commit_kind == K_SRAM && commit_idx == IDX_W'(i))
        sram_q[i] <= commit_data[2*DW-1:0];
    end
  end

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        evq_q[p] <= '0;
        tmr_q[p] <= '0;
      end else if (commit_valid && commit_idx == IDX_W'(p)) begin
        if (commit_kind == K_EVQ) evq_q[p] <= commit_data[DW-1:0];
        if (commit_kind == K_TMR) tmr_q[p] <= commit_data[DW-1:0];
      end
    end
  end

  // R10: descriptor registers and unmapped space read as zero
  always_comb begin
    rd_word = '0;
    case (rd_dec.kind)
      K_CSR:
        for (int i = 0; i < NUM_CSR; i++)
          if (rd_dec.idx == IDX_W'(i)) rd_word = csr_q[i][rd_dec.sel * DW +: DW];
      K_SRAM:
        for (int i = 0; i < NUM_SRAM; i++)
          if (rd_dec.idx == IDX_W'(i)) rd_word = sram_q[i][rd_dec.sel[0] * DW +: DW];
      K_EVQ:
        for (int p = 0; p < NUM_PAGES; p++)
          if (rd_dec.idx == IDX_W'(p)) rd_word = evq_q[p];
      K_TMR:
        for (int p = 0; p < NUM_PAGES; p++)
          if (rd_dec.idx == IDX_W'(p)) rd_word = tmr_q[p];
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_resp_valid <= 1'b0;
      rd_resp_data  <= '0;
    end else begin
      rd_resp_valid <= rd_fire;
      rd_resp_data  <= rd_fire ? rd_word : '0;
    end
  end
endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector
  import wwc_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int NUM_CSR      = 4,
  parameter int CSR_BASE     = 'h000,
  parameter int NUM_SRAM     = 4,
  parameter int SRAM_BASE    = 'h100,
  parameter int NUM_PAGES    = 2,
  parameter int PAGE_STRIDE  = 'h2000,
  parameter bit TIMER_CLEARS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_resp_valid,
  output logic [31:0]       rd_resp_data,
  output logic              commit_valid,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [127:0]      commit_data
);
  dec_t              wr_dec, rd_dec;
  logic [ADDR_W-1:0] wr_base, rd_base_unused;
  kind_e             commit_kind;
  logic [IDX_W-1:0]  commit_idx;

  // R11: never back-pressures
  assign wr_ready = 1'b1;
  assign rd_ready = 1'b1;

  wwc_decode #(
    .ADDR_W(ADDR_W), .NUM_CSR(NUM_CSR), .CSR_BASE(CSR_BASE),
    .NUM_SRAM(NUM_SRAM), .SRAM_BASE(SRAM_BASE),
    .NUM_PAGES(NUM_PAGES), .PAGE_STRIDE(PAGE_STRIDE)
  ) u_wr_dec (
    .addr(wr_addr), .dec(wr_dec), .base(wr_base)
  );

  wwc_decode #(
    .ADDR_W(ADDR_W), .NUM_CSR(NUM_CSR), .CSR_BASE(CSR_BASE),
    .NUM_SRAM(NUM_SRAM), .SRAM_BASE(SRAM_BASE),
    .NUM_PAGES(NUM_PAGES), .PAGE_STRIDE(PAGE_STRIDE)
  ) u_rd_dec (
    .addr(rd_addr), .dec(rd_dec), .base(rd_base_unused)
  );

  wwc_collector #(
    .ADDR_W(ADDR_W), .TIMER_CLEARS(TIMER_CLEARS)
  ) u_col (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_valid && wr_ready), .wr_dec(wr_dec), .wr_base(wr_base),
    .wr_data(wr_data),
    .commit_valid(commit_valid), .commit_addr(commit_addr),
    .commit_data(commit_data), .commit_kind(commit_kind),
    .commit_idx(commit_idx)
  );

  wwc_regfile #(
    .NUM_CSR(NUM_CSR), .NUM_SRAM(NUM_SRAM), .NUM_PAGES(NUM_PAGES)
  ) u_rf (
    .clk(clk), .rst_n(rst_n),
    .commit_valid(commit_valid), .commit_kind(commit_kind),
    .commit_idx(commit_idx), .commit_data(commit_data),
    .rd_fire(rd_valid && rd_ready), .rd_dec(rd_dec),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data)
  );
endmodule

// File: rtl/wwc_checker.sv
module wwc_checker
  import wwc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int NUM_SRAM    = 4,
  parameter int SRAM_BASE   = 'h100,
  parameter int NUM_PAGES   = 2,
  parameter int PAGE_STRIDE = 'h2000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_resp_valid,
  input logic [31:0]       rd_resp_data,
  input logic              commit_valid,
  input logic [ADDR_W-1:0] commit_addr,
  input logic [127:0]      commit_data
);
  localparam int PAGE_SH  = $clog2(PAGE_STRIDE);
  localparam int SRAM_END = SRAM_BASE + 8 * NUM_SRAM;

  logic [ADDR_W-1:0] w_off, r_off;
  logic w_pg, r_pg, w_hi_desc, w_narrow, r_desc, c_sram;

  assign w_off     = wr_addr & ADDR_W'(PAGE_STRIDE - 1);
  assign r_off     = rd_addr & ADDR_W'(PAGE_STRIDE - 1);
  assign w_pg      = int'(wr_addr >> PAGE_SH) < NUM_PAGES;
  assign r_pg      = int'(rd_addr >> PAGE_SH) < NUM_PAGES;
  assign w_hi_desc = w_pg && (w_off == ADDR_W'(OFF_DRX + 12) || w_off == ADDR_W'(OFF_DTX + 12));
  assign w_narrow  = w_pg && (w_off == ADDR_W'(OFF_EVQ) || w_off == ADDR_W'(OFF_TMR));
  assign r_desc    = r_pg && ((r_off & ~ADDR_W'(15)) == ADDR_W'(OFF_DRX) ||
                              (r_off & ~ADDR_W'(15)) == ADDR_W'(OFF_DTX));
  assign c_sram    = int'(commit_addr) >= SRAM_BASE && int'(commit_addr) < SRAM_END;

  assert_always_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready && rd_ready);

  assert_commit_has_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> $past(wr_valid));

  assert_desc_high_commits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && w_hi_desc) |=>
      (commit_valid && commit_data[127:96] == $past(wr_data) &&
       commit_addr == ($past(wr_addr) & ~ADDR_W'(15))));

  assert_narrow_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && w_narrow) |=>
      (commit_valid && commit_data[127:32] == '0 && commit_data[31:0] == $past(wr_data) &&
       commit_addr == $past(wr_addr)));

  assert_far_page_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !w_pg) |=> !commit_valid);

  assert_sram_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && c_sram) |-> commit_data[127:64] == '0);

  assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rd_resp_valid);

  assert_desc_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && r_desc) |=> (rd_resp_data == '0));
endmodule

bind wide_write_collector wwc_checker #(
  .ADDR_W(ADDR_W), .NUM_SRAM(NUM_SRAM), .SRAM_BASE(SRAM_BASE),
  .NUM_PAGES(NUM_PAGES), .PAGE_STRIDE(PAGE_STRIDE)
) i_wwc_checker (
  .clk(clk), .rst_n(rst_n),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
  .commit_valid(commit_valid), .commit_addr(commit_addr), .commit_data(commit_data)
);

// File: tb/test_wide_write_collector.sv
module test_wide_write_collector;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [15:0]  wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         rd_valid = 1'b0;
  logic         rd_ready;
  logic [15:0]  rd_addr = '0;
  logic         rd_resp_valid;
  logic [31:0]  rd_resp_data;
  logic         commit_valid;
  logic [15:0]  commit_addr;
  logic [127:0] commit_data;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  string cur_req  = "R11";

  always #5 clk = ~clk;

  wide_write_collector i_wide_write_collector (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .commit_valid(commit_valid), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  task automatic check(input bit ok, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  // behavioural reference: one shared collector, default geometry
  int         m_kind = 0;
  int         m_idx  = 0;
  bit [3:0]   m_mask = '0;
  bit [127:0] m_data = '0;

  task automatic model_write(input int a, input bit [31:0] d, output bit ev,
                             output int ea, output bit [127:0] ed);
    int kind = 0, idx = 0, sel = 0, base = 0, pg, off;
    bit hit;
    bit [3:0] mm, full;
    bit [127:0] acc;
    ev = 0; ea = 0; ed = '0;
    pg = a / 8192;
    off = a % 8192;
    if (a < 64) begin
      kind = 1; idx = a / 16; sel = (a % 16) / 4; base = a - (a % 16);
    end else if (a >= 256 && a < 288) begin
      kind = 2; idx = (a - 256) / 8; sel = (a % 8) / 4; base = a - (a % 8);
    end else if (pg < 2) begin
      idx = pg; sel = (off % 16) / 4; base = a - (a % 16);
      if (off == 1024) begin kind = 3; base = a; end
      else if (off == 1056) begin kind = 4; base = a; end
      else if (off >= 2096 && off < 2112) kind = 5;
      else if (off >= 2576 && off < 2592) kind = 6;
    end
    hit = (m_mask != 0) && (m_kind == kind) && (m_idx == idx);
    mm  = hit ? m_mask : 4'b0;
    acc = hit ? m_data : '0;
    mm[sel] = 1'b1;
    acc[sel*32 +: 32] = d;
    full = (kind == 2) ? 4'b0011 : 4'b1111;
    case (kind)
      1, 2: begin
        if (mm == full) begin
          ev = 1; ea = base; ed = acc; m_mask = 0; m_data = 0;
        end else begin
          m_mask = mm; m_data = acc; m_kind = kind; m_idx = idx;
        end
      end
      5, 6: begin
        if (sel == 3) begin
          ev = 1; ea = base; ed = {d, (hit ? m_data[95:0] : 96'b0)};
          if (hit) begin m_mask = 0; m_data = 0; end
        end else if (m_mask == 0 || hit) begin
          m_mask = mm; m_data = acc; m_kind = kind; m_idx = idx;
        end
      end
      3, 4: begin
        ev = 1; ea = base; ed = {96'b0, d};
        if (kind == 4 && idx == 0) begin m_mask = 0; m_data = 0; end
      end
      default: ;
    endcase
  endtask

  task automatic wr(input int a, input bit [31:0] d);
    bit ev; int ea; bit [127:0] ed;
    model_write(a, d, ev, ea, ed);
    wr_valid = 1'b1; wr_addr = 16'(a); wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    check(commit_valid == ev, "commit strobe", 128'(commit_valid), 128'(ev));
    if (ev) begin
      check(commit_addr == 16'(ea), "commit address", 128'(commit_addr), 128'(ea));
      check(commit_data == ed, "commit data", commit_data, ed);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      check(commit_valid == 1'b0, "strobe held low", 128'(commit_valid), 128'(0));
    end
  endtask

  task automatic rd(input int a, input bit [31:0] exp);
    rd_valid = 1'b1; rd_addr = 16'(a);
    @(negedge clk);
    rd_valid = 1'b0;
    check(rd_resp_valid == 1'b1, "read response valid", 128'(rd_resp_valid), 128'(1));
    check(rd_resp_data == exp, "read data", 128'(rd_resp_data), 128'(exp));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R11";
    check(commit_valid == 1'b0, "no commit in reset", 128'(commit_valid), 128'(0));
    check(rd_resp_valid == 1'b0, "no read in reset", 128'(rd_resp_valid), 128'(0));
    rst_n = 1'b1;
    idle(1);
    check(wr_ready && rd_ready, "ready held high", 128'({wr_ready, rd_ready}), 128'(3));
    rd('h010, 32'h0);
    rd('h2420, 32'h0);

    cur_req = "R1";  // shuffled order into register 1 (base 0x010)
    wr('h01C, 32'hD3D3_0003); wr('h010, 32'hD0D0_0000);
    wr('h018, 32'hD2D2_0002); wr('h014, 32'hD1D1_0001);
    idle(2);
    rd('h018, 32'hD2D2_0002);
    rd('h014, 32'hD1D1_0001);

    cur_req = "R2";
    wr('h10C, 32'hBBBB_0001); wr('h108, 32'hAAAA_0000);
    idle(2);
    rd('h10C, 32'hBBBB_0001);

    cur_req = "R4";
    wr('h000, 32'h1111_1111); wr('h000, 32'h2222_2222);
    wr('h004, 32'h3); wr('h008, 32'h4); wr('h00C, 32'h5);
    idle(2);
    rd('h000, 32'h2222_2222);

    cur_req = "R3";  // interleave registers 0 and 2: partial data is lost
    wr('h000, 32'hA0); wr('h004, 32'hA1);
    wr('h020, 32'hC0);
    wr('h024, 32'hC1); wr('h028, 32'hC2); wr('h02C, 32'hC3);
    wr('h008, 32'hA2); wr('h00C, 32'hA3);
    wr('h000, 32'hB0);
    wr('h004, 32'hB1); wr('h008, 32'hB2); wr('h00C, 32'hB3);
    wr('h020, 32'hE0); wr('h108, 32'hE1);
    wr('h10C, 32'hE2);
    idle(2);
    rd('h020, 32'hC0);
    rd('h108, 32'hE1);

    cur_req = "R5";
    wr('h830, 32'h5000); wr('h834, 32'h5001); wr('h83C, 32'h5003);
    wr('h2A1C, 32'h6003);
    wr('h010, 32'h7000); wr('h83C, 32'h7777);
    wr('h014, 32'h7001); wr('h018, 32'h7002); wr('h01C, 32'h7003);

    cur_req = "R6";
    wr('h030, 32'h8000); wr('h034, 32'h8001);
    wr('h830, 32'hDEAD); wr('h2A18, 32'hBEEF);
    wr('h038, 32'h8002); wr('h03C, 32'h8003);
    wr('h83C, 32'h9003);

    cur_req = "R7";
    wr('h000, 32'hF0); wr('h2400, 32'h0000_4321);
    wr('h004, 32'hF1); wr('h008, 32'hF2); wr('h00C, 32'hF3);
    idle(2);
    rd('h2400, 32'h0000_4321);
    rd('h000, 32'hF0);

    cur_req = "R8";
    wr('h000, 32'h10); wr('h004, 32'h11); wr('h008, 32'h12);
    wr('h2420, 32'h77);
    wr('h00C, 32'h13);
    wr('h000, 32'h20); wr('h004, 32'h21); wr('h008, 32'h22);
    wr('h420, 32'h66);
    wr('h00C, 32'h23);
    idle(2);
    rd('h004, 32'h11);
    rd('h420, 32'h66);

    cur_req = "R9";
    wr('h4400, 32'h99); wr('h4A1C, 32'h98); wr('h050, 32'h97);
    idle(2);
    rd('h4400, 32'h0);
    rd('h050, 32'h0);

    cur_req = "R10";
    rd('h830, 32'h0);
    rd('h2A1C, 32'h0);
    wr('h010, 32'hCAFE);
    idle(2);
    rd('h010, 32'h7000);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule